// File: doc/BRIEF.md
# Pin-Selected Output Clock Divider

This block divides a fast clock, normally the output of an on-chip frequency synthesizer, by a ratio picked with a 3-bit select input. The result drives the final output clock. A build-time parameter chooses one of two select tables. The low-jitter table offers ratios from 2 to 10. The high-frequency table drops 9 and 10 and adds a divide-by-3 and a bypass divide-by-1, in which the fast clock itself reaches the output. Even ratios give a square wave. Odd ratios give a low phase one fast cycle longer than the high phase.

The select may change while the divider runs. A new ratio is taken up only at the end of the output period in progress, so no period is cut short. An active-low power-down input stops the output and holds it low. Leaving power-down restarts the divider from count zero with the output low. A 4-bit output reports the ratio in force, so a testbench or a monitor can read the division without counting edges.

Top module: `pinsel_clkdiv`

## Requirements
- R1: With VARIANT=0, select codes 0 through 7 (sel[2] as MSB) give the active ratios 10, 2, 8, 4, 5, 7, 9 and 6 respectively.
- R2: With VARIANT=1, select codes 0 through 7 give the active ratios 6, 2, 8, 4, 5, 7, 1 and 3 respectively.
- R3: For an even ratio N the output is low for N/2 fast-clock cycles and then high for N/2 cycles.
- R4: For an odd ratio N of 3 or more, the output is low for (N+1)/2 cycles and then high for (N-1)/2 cycles.
- R5: At ratio 1 the output equals the fast clock: high while it is high, low while it is low. Entering or leaving ratio 1 produces no pulse shorter than half a fast cycle.
- R6: A change of select takes effect only at the first fast-clock edge after the current output period ends. Until then both the ratio report and the waveform keep the old ratio.
- R7: While pwr_n is low, the output is low from the first falling edge of the fast clock after pwr_n is sampled low. During that time the ratio report follows the select one cycle later.
- R8: On the first rising edge with pwr_n high after power-down or reset, the divider starts at count zero with the output low. A full low phase of the selected ratio follows.
- R9: A synchronous reset forces the output low and sets the ratio report to the ratio of select code 7 (6 for VARIANT=0, 3 for VARIANT=1).
- R10: ratio_o carries the active ratio as unsigned binary. It changes on the same edge as the first cycle of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| pwr_n | input | 1 | Active-low power-down; low parks the output low |
| sel | input | 3 | Ratio select code |
| clk_out | output | 1 | Divided output clock |
| ratio_o | output | RW (4) | Ratio currently in force, unsigned binary |

## Verification
A wrong count or a wrong stored ratio shows at clk_out within one output period, as a low or high phase of the wrong length. The cycle-accurate model sees this on the first wrong fast cycle. A stored ratio taken up at the wrong moment shows at ratio_o on the very edge where it changes, before the waveform has had time to differ. A fault in the bypass gate shows within half a fast cycle, because both halves of every fast cycle are sampled.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int VAR_LOWJIT = 0;
  localparam int VAR_HIFREQ = 1;

  // Ratio for one select code under one variant. The code order is behaviour.
  function automatic int ratio_of(input int variant, input logic [2:0] code);
    int r;
    if (variant == VAR_HIFREQ) begin
      case (code)
        3'd0: r = 6;
        3'd1: r = 2;
        3'd2: r = 8;
        3'd3: r = 4;
        3'd4: r = 5;
        3'd5: r = 7;
        3'd6: r = 1;
        default: r = 3;
      endcase
    end else begin
      case (code)
        3'd0: r = 10;
        3'd1: r = 2;
        3'd2: r = 8;
        3'd3: r = 4;
        3'd4: r = 5;
        3'd5: r = 7;
        3'd6: r = 9;
        default: r = 6;
      endcase
    end
    return r;
  endfunction

  // True when r is reachable from some select code of the variant.
  function automatic logic is_legal(input int variant, input int r);
    logic hit;
    hit = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (ratio_of(variant, 3'(c)) == r) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/clkdiv_ratio_map.sv
module clkdiv_ratio_map
  import clkdiv_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int RW      = 4,
  parameter int SW      = 3
) (
  input  logic [SW-1:0] sel,
  output logic [RW-1:0] ratio
);

  localparam int NCODES = 1 << SW;

  logic [RW-1:0] tbl [NCODES];

  // Build the constant table, one entry per code.
  generate
    for (genvar c = 0; c < NCODES; c++) begin : g_code
      if (VARIANT == VAR_HIFREQ) begin : g_hf
        assign tbl[c] = RW'(ratio_of(VAR_HIFREQ, 3'(c)));
      end else begin : g_lj
        assign tbl[c] = RW'(ratio_of(VAR_LOWJIT, 3'(c)));
      end
    end
  endgenerate

  assign ratio = tbl[sel];

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int            RW    = 4,
  parameter logic [RW-1:0] DFLT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_n,
  input  logic [RW-1:0] sel_ratio,
  output logic          run_q,
  output logic [RW-1:0] cnt_q,
  output logic [RW-1:0] ratio_q,
  output logic          out_q
);

  localparam logic [RW-1:0] ONE = RW'(1);

  logic          wrap;
  logic [RW-1:0] cnt_nxt;
  logic [RW-1:0] ratio_nxt;
  logic [RW-1:0] low_len;
  logic          hi_nxt;

  // End of period: the last count of the ratio in force.
  assign wrap      = (cnt_q == ratio_q - ONE);
  assign cnt_nxt   = wrap ? '0 : cnt_q + ONE;
  assign ratio_nxt = wrap ? sel_ratio : ratio_q;
  // The low phase takes the larger half, so odd ratios run low-heavy.
  assign low_len   = ratio_nxt - (ratio_nxt >> 1);
  assign hi_nxt    = (cnt_nxt >= low_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
      ratio_q <= DFLT;
    end else if (!pwr_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
      ratio_q <= sel_ratio;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      ratio_q <= ratio_nxt;
      out_q   <= hi_nxt;
    end
  end

endmodule

// File: rtl/clkdiv_bypass.sv
module clkdiv_bypass #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_q,
  input  logic [RW-1:0] ratio_q,
  input  logic          div_q,
  output logic          gate_q,
  output logic          clk_out
);

  localparam logic [RW-1:0] ONE = RW'(1);

  // The pass-through select changes only while clk is low, so the
  // mux never cuts a high phase of either source.
  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= run_q && (ratio_q == ONE);
  end

  assign clk_out = gate_q ? clk : div_q;

endmodule

// File: rtl/pinsel_clkdiv.sv
module pinsel_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int RW      = 4
) (
  input  logic          clk_fast,
  input  logic          rst,
  input  logic          pwr_n,
  input  logic [2:0]    sel,
  output logic          clk_out,
  output logic [RW-1:0] ratio_o
);

  localparam logic [RW-1:0] DFLT = RW'(ratio_of(VARIANT, 3'b111));

  logic [RW-1:0] sel_ratio;
  logic          run_q;
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] ratio_q;
  logic          out_q;
  logic          gate_q;

  clkdiv_ratio_map #(.VARIANT(VARIANT), .RW(RW), .SW(3)) u_map (
    .sel   (sel),
    .ratio (sel_ratio)
  );

  clkdiv_core #(.RW(RW), .DFLT(DFLT)) u_core (
    .clk       (clk_fast),
    .rst       (rst),
    .pwr_n     (pwr_n),
    .sel_ratio (sel_ratio),
    .run_q     (run_q),
    .cnt_q     (cnt_q),
    .ratio_q   (ratio_q),
    .out_q     (out_q)
  );

  clkdiv_bypass #(.RW(RW)) u_byp (
    .clk     (clk_fast),
    .rst     (rst),
    .run_q   (run_q),
    .ratio_q (ratio_q),
    .div_q   (out_q),
    .gate_q  (gate_q),
    .clk_out (clk_out)
  );

  assign ratio_o = ratio_q;

endmodule

// File: rtl/pinsel_clkdiv_chk.sv
module pinsel_clkdiv_chk
  import clkdiv_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int RW      = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          pwr_n,
  input logic [RW-1:0] ratio_o,
  input logic          run_q,
  input logic [RW-1:0] cnt_q,
  input logic          out_q,
  input logic          gate_q
);

  // R1, R2: the reported ratio is always one the variant's table holds
  a_r1_r2_legal: assert property (@(posedge clk) disable iff (rst)
    is_legal(VARIANT, int'(ratio_o)));

  // R3, R4: the phase counter stays inside the active period
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < ratio_o));

  // R5: the pass-through gate is open only while running at ratio 1
  a_r5_gate_ratio: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> (run_q && ratio_o == RW'(1)));

  // R6: the ratio stays put except on the last count of a period
  a_r6_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
    (run_q && pwr_n && cnt_q != ratio_o - RW'(1)) |=> $stable(ratio_o));

  // R7: power-down parks the divider low and stopped
  a_r7_pd_low: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> (!out_q && !run_q));

  // R8: leaving power-down starts at count zero with the output low
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    (!run_q && pwr_n) |=> (run_q && cnt_q == '0 && !out_q));

endmodule

bind pinsel_clkdiv pinsel_clkdiv_chk #(.VARIANT(VARIANT), .RW(RW)) u_chk (
  .clk     (clk_fast),
  .rst     (rst),
  .pwr_n   (pwr_n),
  .ratio_o (ratio_o),
  .run_q   (run_q),
  .cnt_q   (cnt_q),
  .out_q   (out_q),
  .gate_q  (gate_q)
);

// File: tb/pinsel_clkdiv_tb.sv
module pinsel_clkdiv_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk_fast = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_n = 1'b1;
  logic [2:0] sel = 3'b111;

  logic       co [2];
  logic [3:0] ro [2];

  pinsel_clkdiv #(.VARIANT(0), .RW(4)) u_dut (
    .clk_fast (clk_fast), .rst (rst), .pwr_n (pwr_n), .sel (sel),
    .clk_out (co[0]), .ratio_o (ro[0])
  );

  pinsel_clkdiv #(.VARIANT(1), .RW(4)) u_dut_hf (
    .clk_fast (clk_fast), .rst (rst), .pwr_n (pwr_n), .sel (sel),
    .clk_out (co[1]), .ratio_o (ro[1])
  );

  always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R9";
  bit cmp_en = 1'b0;

  int tA [8] = '{10, 2, 8, 4, 5, 7, 9, 6};
  int tB [8] = '{6, 2, 8, 4, 5, 7, 1, 3};

  // behavioural reference state, one set per instance
  int m_run [2];
  int m_cnt [2];
  int m_ratio [2];
  int m_out [2];
  int m_gate [2];
  logic hi_s [2];
  logic lo_s [2];

  function automatic int tbl(int i, int code);
    return (i == 0) ? tA[code] : tB[code];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(int i);
    if (rst) begin
      m_run[i] = 0; m_cnt[i] = 0; m_out[i] = 0; m_ratio[i] = tbl(i, 7);
    end else if (!pwr_n) begin
      m_run[i] = 0; m_cnt[i] = 0; m_out[i] = 0; m_ratio[i] = tbl(i, int'(sel));
    end else if (m_run[i] == 0) begin
      m_run[i] = 1; m_cnt[i] = 0; m_out[i] = 0;
    end else begin
      if (m_cnt[i] == m_ratio[i] - 1) begin
        m_cnt[i] = 0;
        m_ratio[i] = tbl(i, int'(sel));
      end else begin
        m_cnt[i]++;
      end
      m_out[i] = (m_cnt[i] >= m_ratio[i] - m_ratio[i] / 2) ? 1 : 0;
    end
  endtask

  // One fast cycle: sample in the high half and in the low half.
  task automatic cycle();
    @(posedge clk_fast);
    for (int i = 0; i < 2; i++) model_step(i);
    #(CLK_PERIOD/4);
    for (int i = 0; i < 2; i++) begin
      hi_s[i] = co[i];
      if (cmp_en) begin
        int e;
        e = (m_gate[i] != 0) ? 1 : m_out[i];
        chk(co[i] === 1'(e), cur_tag, int'(co[i]), e);
        chk(ro[i] === 4'(m_ratio[i]), cur_tag, int'(ro[i]), m_ratio[i]);
      end
    end
    @(negedge clk_fast);
    for (int i = 0; i < 2; i++)
      m_gate[i] = (!rst && m_run[i] != 0 && m_ratio[i] == 1) ? 1 : 0;
    #(CLK_PERIOD/4);
    for (int i = 0; i < 2; i++) begin
      lo_s[i] = co[i];
      if (cmp_en) begin
        int e;
        e = (m_gate[i] != 0) ? 0 : m_out[i];
        chk(co[i] === 1'(e), cur_tag, int'(co[i]), e);
      end
    end
  endtask

  task automatic run_cycles(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  // Measure one full low and high phase of instance i in fast cycles.
  task automatic measure(int i, int n);
    int h;
    int l;
    int guard;
    logic prev;
    string tg;
    tg = (n % 2 == 0) ? "R3" : "R4";
    guard = 0;
    prev = lo_s[i];
    cycle();
    while (!(!prev && lo_s[i]) && guard < 40) begin
      prev = lo_s[i];
      cycle();
      guard++;
    end
    h = 1;
    guard = 0;
    cycle();
    while (lo_s[i] && guard < 40) begin h++; cycle(); guard++; end
    l = 1;
    guard = 0;
    cycle();
    while (!lo_s[i] && guard < 40) begin l++; cycle(); guard++; end
    chk(h == n / 2, tg, h, n / 2);
    chk(l == n - n / 2, tg, l, n - n / 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_run[i] = 0; m_cnt[i] = 0; m_ratio[i] = 0; m_out[i] = 0; m_gate[i] = 0;
    end
    // R9: reset state
    cur_tag = "R9";
    cycle();
    cmp_en = 1'b1;
    run_cycles(2);
    chk(ro[0] == 4'd6, "R9", int'(ro[0]), 6);
    chk(ro[1] == 4'd3, "R9", int'(ro[1]), 3);
    chk(lo_s[0] == 1'b0 && hi_s[0] == 1'b0, "R9", int'(hi_s[0]), 0);
    rst = 1'b0;

    // R1, R2, R3, R4: every code on both variants
    for (int c = 0; c < 8; c++) begin
      cur_tag = "R1";
      sel = 3'(c);
      run_cycles(25);
      chk(ro[0] == 4'(tA[c]), "R1", int'(ro[0]), tA[c]);
      chk(ro[1] == 4'(tB[c]), "R2", int'(ro[1]), tB[c]);
      cur_tag = "R3";
      measure(0, tA[c]);
      if (tB[c] != 1) measure(1, tB[c]);
    end

    // R5: bypass on the high-frequency variant, with entry and exit
    cur_tag = "R5";
    sel = 3'd6;
    run_cycles(12);
    for (int k = 0; k < 4; k++) begin
      cycle();
      chk(hi_s[1] == 1'b1 && lo_s[1] == 1'b0, "R5", int'(hi_s[1]), 1);
    end
    sel = 3'd1;
    run_cycles(8);
    sel = 3'd6;
    run_cycles(8);
    sel = 3'd0;
    run_cycles(12);

    // R6, R10: change select in mid-period on the low-jitter variant
    cur_tag = "R6";
    sel = 3'd0;
    run_cycles(25);
    begin
      int guard;
      logic prev;
      guard = 0;
      prev = lo_s[0];
      cycle();
      while (!(!prev && lo_s[0]) && guard < 40) begin
        prev = lo_s[0]; cycle(); guard++;
      end
    end
    sel = 3'd1;
    for (int k = 0; k < 4; k++) begin
      cycle();
      chk(ro[0] == 4'd10, "R6", int'(ro[0]), 10);
      chk(lo_s[0] == 1'b1, "R6", int'(lo_s[0]), 1);
    end
    cycle();
    chk(ro[0] == 4'd2, "R10", int'(ro[0]), 2);
    chk(lo_s[0] == 1'b0, "R6", int'(lo_s[0]), 0);
    run_cycles(6);

    // R7: power-down from a high phase, with the select moving
    cur_tag = "R7";
    sel = 3'd6;
    run_cycles(30);
    pwr_n = 1'b0;
    cycle();
    chk(lo_s[0] == 1'b0 && lo_s[1] == 1'b0, "R7", int'(lo_s[1]), 0);
    for (int k = 0; k < 6; k++) begin
      cycle();
      chk(hi_s[0] == 1'b0 && hi_s[1] == 1'b0, "R7", int'(hi_s[1]), 0);
    end
    sel = 3'd3;
    cycle();
    chk(ro[0] == 4'd4, "R7", int'(ro[0]), 4);

    // R8: restart from count zero with a full low phase
    cur_tag = "R8";
    pwr_n = 1'b1;
    cycle();
    chk(lo_s[0] == 1'b0, "R8", int'(lo_s[0]), 0);
    cycle();
    chk(lo_s[0] == 1'b0, "R8", int'(lo_s[0]), 0);
    cycle();
    chk(lo_s[0] == 1'b1, "R8", int'(lo_s[0]), 1);
    run_cycles(20);

    // R9: reset while running
    cur_tag = "R9";
    rst = 1'b1;
    cycle();
    chk(ro[0] == 4'd6 && lo_s[0] == 1'b0, "R9", int'(ro[0]), 6);
    rst = 1'b0;
    run_cycles(10);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule